// File: doc/BRIEF.md
# Audio Serial Clock Generator

This block derives every audio-rate timing signal from a single master clock that runs at 384 times the sample rate. A frame position counter walks through the 384 master cycles of one sample period, and every output is decoded from that position: a 64fs clock for an external converter, a left/right frame signal, and a bit clock and word clock for each of two output serial ports. Each port's bit clock runs at either 32fs or 48fs, chosen by its own rate pin.

The frame can follow the internal counter or an external left/right input, chosen by a select pin. In external mode the input is synchronised, and each detected edge snaps the counter to the start of the matching half-frame. The counter then runs freely until the next edge.

The block also serialises one stereo pair onto a data output. The pair is captured at frame start and sent MSB first. The data changes on falling edges of port A's bit clock.

Top module: `audio_clkgen`

## Requirements
- R1: While rst_n is low, every output is low and the captured samples are cleared. The frame position p is 0 during reset. The first master edge after release moves p to 1, and outputs then follow the rules below for that p.
- R2: On each master edge p advances by one and wraps from 383 to 0. After the edge, lr_frame is 1 (left) for p from 0 to 191 and 0 (right) for p from 192 to 383. wck_a and wck_b carry the same level as lr_frame.
- R3: conv_clk has a period of 6 master cycles. It is low when p mod 6 is 0, 1 or 2 and high when it is 3, 4 or 5.
- R4: With its rate pin at 0 (32fs), a port's bit clock is high when p mod 12 is at least 6. With the pin at 1 (48fs), it is high when p mod 8 is at least 4. As a result, conv_clk and both bit clocks are low at p = 0.
- R5: Let P be 12 or 8, set by rate_a. Let o = p mod 192 and slot k = o / P. sd_out carries bit (23 - k) of the left word while p < 192 and of the right word otherwise. This gives 16 bits MSB first (bits 23 to 8) per channel at 32fs and 24 bits at 48fs, changing only where bck_a falls.
- R6: smp_l and smp_r are captured on the edge that moves p to 0. Changes at any other time have no effect on sd_out until the next frame.
- R7: With frame_int at 0, lr_ext passes through two synchroniser flops. A rise seen there forces p to 0 on the following edge, and a fall forces p to 192. A rise sampled at edge n therefore gives p = 0 after edge n+2.
- R8: With frame_int at 0 and no edge on lr_ext, p keeps advancing and wrapping exactly as in R2.
- R9: With frame_int at 1, lr_ext has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_384 | input | 1 | Master clock at 384 times the sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_int | input | 1 | 1: internal framing, 0: follow lr_ext |
| lr_ext | input | 1 | External left/right frame input, high = left |
| rate_a | input | 1 | Port A bit-clock rate, 0 = 32fs, 1 = 48fs |
| rate_b | input | 1 | Port B bit-clock rate, 0 = 32fs, 1 = 48fs |
| smp_l | input | 24 | Left sample word |
| smp_r | input | 24 | Right sample word |
| conv_clk | output | 1 | 64fs converter clock |
| bck_a | output | 1 | Port A bit clock |
| wck_a | output | 1 | Port A word clock |
| bck_b | output | 1 | Port B bit clock |
| wck_b | output | 1 | Port B word clock |
| lr_frame | output | 1 | Frame signal, high = left |
| sd_out | output | 1 | Serial stereo data aligned to port A |

## Verification
The data-hold property assumes that rate_a stays put and that no resynchronisation happens during a bit-clock high phase. It is therefore guarded by both conditions, and the bench moves rate pins at arbitrary cycles so that the guard is exercised. The resynchronisation properties assume that lr_ext is a level held for many master cycles. The bench drives it only on falling master edges, with high and low times of tens to hundreds of cycles, and includes both regular 384-cycle frames and irregular ones that force mid-frame jumps.

// File: rtl/acg_pkg.sv
package acg_pkg;

  // level of a divided clock at a given frame position: low first half, high second half
  function automatic logic clk_level(input int unsigned pos, input int unsigned div);
    return ((pos % div) >= (div / 2)) ? 1'b1 : 1'b0;
  endfunction

  // data slot number inside a half frame
  function automatic int unsigned slot_of(input int unsigned pos, input int unsigned half,
                                          input int unsigned div);
    return (pos % half) / div;
  endfunction

endpackage

// File: rtl/acg_frame_counter.sv
module acg_frame_counter #(
  parameter int FRAME = 384,
  parameter int PW    = $clog2(FRAME)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          use_int,
  input  logic          lr_ext,
  output logic [PW-1:0] phase_nxt,
  output logic          resync_l,
  output logic          resync_r
);
  localparam logic [PW-1:0] LAST = PW'(FRAME - 1);
  localparam logic [PW-1:0] HALF = PW'(FRAME / 2);

  logic [PW-1:0] phase;
  logic [2:0]    sync_q;   // [0],[1] synchroniser, [2] edge history
  logic          ext_rise;
  logic          ext_fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= '0;
      sync_q <= '0;
    end else begin
      phase  <= phase_nxt;
      sync_q <= {sync_q[1:0], lr_ext};
    end
  end

  always_comb begin
    ext_rise = sync_q[1] & ~sync_q[2];
    ext_fall = ~sync_q[1] & sync_q[2];
    resync_l = ~use_int & ext_rise;
    resync_r = ~use_int & ext_fall;
    if (resync_l)          phase_nxt = '0;
    else if (resync_r)     phase_nxt = HALF;
    else if (phase == LAST) phase_nxt = '0;
    else                   phase_nxt = phase + 1'b1;
  end

  AST_PHASE_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!resync_l && !resync_r && phase == LAST) |=> (phase == '0)); // R2

  AST_RESYNC_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
    resync_l |=> (phase == '0)); // R7

  AST_RESYNC_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    resync_r |=> (phase == HALF)); // R7

endmodule

// File: rtl/acg_div_out.sv
module acg_div_out #(
  parameter int PW    = 9,
  parameter int DIV_A = 12,
  parameter int DIV_B = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sel,
  input  logic [PW-1:0] phase_nxt,
  output logic          level
);
  localparam int unsigned DA = DIV_A;
  localparam int unsigned DB = DIV_B;

  logic lvl_d;

  always_comb lvl_d = acg_pkg::clk_level(32'(phase_nxt), sel ? DB : DA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) level <= 1'b0;
    else        level <= lvl_d;
  end
endmodule

// File: rtl/acg_serializer.sv
module acg_serializer #(
  parameter int FRAME    = 384,
  parameter int PW       = $clog2(FRAME),
  parameter int SW       = 24,
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rate,
  input  logic [PW-1:0] phase_nxt,
  input  logic [SW-1:0] smp_l,
  input  logic [SW-1:0] smp_r,
  output logic          sd
);
  localparam int unsigned HALF = FRAME / 2;
  localparam int unsigned DS   = DIV_SLOW;
  localparam int unsigned DF   = DIV_FAST;
  localparam int          BW   = $clog2(SW);

  logic [SW-1:0] hold_l, hold_r, word;
  logic          cap, left;
  int unsigned   slot;
  logic [BW-1:0] bsel;

  always_comb begin
    cap  = (phase_nxt == '0);
    left = (32'(phase_nxt) < HALF);
    slot = acg_pkg::slot_of(32'(phase_nxt), HALF, rate ? DF : DS);
    bsel = BW'(SW - 1 - int'(slot));
    if (left) word = cap ? smp_l : hold_l;
    else      word = hold_r;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_l <= '0;
      hold_r <= '0;
      sd     <= 1'b0;
    end else begin
      if (cap) begin
        hold_l <= smp_l;
        hold_r <= smp_r;
      end
      sd <= word[bsel];
    end
  end
endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen #(
  parameter int FRAME    = 384,
  parameter int SW       = 24,
  parameter int CONV_DIV = 6,
  parameter int DIV_SLOW = 12,
  parameter int DIV_FAST = 8
) (
  input  logic          clk_384,
  input  logic          rst_n,
  input  logic          frame_int,
  input  logic          lr_ext,
  input  logic          rate_a,
  input  logic          rate_b,
  input  logic [SW-1:0] smp_l,
  input  logic [SW-1:0] smp_r,
  output logic          conv_clk,
  output logic          bck_a,
  output logic          wck_a,
  output logic          bck_b,
  output logic          wck_b,
  output logic          lr_frame,
  output logic          sd_out
);
  localparam int PW    = $clog2(FRAME);
  localparam int NPORT = 2;
  localparam logic [PW-1:0] HALF = PW'(FRAME / 2);

  logic [PW-1:0]    phase_nxt;
  logic             resync_l, resync_r, resync_any;
  logic [NPORT-1:0] rate_v, bck_v;
  logic             lr_q;

  acg_frame_counter #(.FRAME(FRAME), .PW(PW)) u_frame (
    .clk(clk_384), .rst_n(rst_n), .use_int(frame_int), .lr_ext(lr_ext),
    .phase_nxt(phase_nxt), .resync_l(resync_l), .resync_r(resync_r)
  );

  acg_div_out #(.PW(PW), .DIV_A(CONV_DIV), .DIV_B(CONV_DIV)) u_conv (
    .clk(clk_384), .rst_n(rst_n), .sel(1'b0), .phase_nxt(phase_nxt), .level(conv_clk)
  );

  assign rate_v = {rate_b, rate_a};

  generate
    for (genvar p = 0; p < NPORT; p++) begin : g_port
      acg_div_out #(.PW(PW), .DIV_A(DIV_SLOW), .DIV_B(DIV_FAST)) u_bck (
        .clk(clk_384), .rst_n(rst_n), .sel(rate_v[p]), .phase_nxt(phase_nxt),
        .level(bck_v[p])
      );
    end
  endgenerate

  acg_serializer #(.FRAME(FRAME), .PW(PW), .SW(SW), .DIV_SLOW(DIV_SLOW),
                   .DIV_FAST(DIV_FAST)) u_ser (
    .clk(clk_384), .rst_n(rst_n), .rate(rate_a), .phase_nxt(phase_nxt),
    .smp_l(smp_l), .smp_r(smp_r), .sd(sd_out)
  );

  always_ff @(posedge clk_384 or negedge rst_n) begin
    if (!rst_n) lr_q <= 1'b0;
    else        lr_q <= (phase_nxt < HALF);
  end

  assign resync_any = resync_l | resync_r;
  assign bck_a      = bck_v[0];
  assign bck_b      = bck_v[1];
  assign lr_frame   = lr_q;
  assign wck_a      = lr_q;
  assign wck_b      = lr_q;

  AST_START_ALIGN: assert property (@(posedge clk_384) disable iff (!rst_n)
    $rose(lr_frame) |-> (!conv_clk && !bck_a && !bck_b)); // R4

  AST_SD_HOLD: assert property (@(posedge clk_384) disable iff (!rst_n)
    (bck_a && $past(bck_a) && !resync_any && $stable(rate_a)) |-> $stable(sd_out)); // R5

endmodule

// File: tb/audio_clkgen_tb.sv
module audio_clkgen_tb;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst_n, frame_int, lr_ext, rate_a, rate_b;
  logic [23:0] smp_l, smp_r;
  logic        conv_clk, bck_a, wck_a, bck_b, wck_b, lr_frame, sd_out;

  audio_clkgen u_dut (
    .clk_384(clk), .rst_n(rst_n), .frame_int(frame_int), .lr_ext(lr_ext),
    .rate_a(rate_a), .rate_b(rate_b), .smp_l(smp_l), .smp_r(smp_r),
    .conv_clk(conv_clk), .bck_a(bck_a), .wck_a(wck_a), .bck_b(bck_b), .wck_b(wck_b),
    .lr_frame(lr_frame), .sd_out(sd_out)
  );

  int    checks = 0;
  int    fails  = 0;
  bit    chk_on = 1'b0;
  string sect   = "R1";

  // bench model of the frame position, built from the requirements
  int          ph = 0;
  bit          m1, m2, m3, in_rst = 1'b1, mra, mrb;
  logic [23:0] lat_l = '0, lat_r = '0;

  always @(posedge clk) begin
    if (!rst_n) begin
      ph = 0; m1 = 0; m2 = 0; m3 = 0; lat_l = '0; lat_r = '0; in_rst = 1'b1;
    end else begin
      in_rst = 1'b0;
      if (!frame_int && m2 && !m3)      ph = 0;     // R7 left start
      else if (!frame_int && !m2 && m3) ph = 192;   // R7 right start
      else                              ph = (ph == 383) ? 0 : ph + 1;
      m3 = m2; m2 = m1; m1 = lr_ext;
      if (ph == 0) begin lat_l = smp_l; lat_r = smp_r; end   // R6
      mra = rate_a; mrb = rate_b;
    end
  end

  function automatic bit e_conv(int p);
    return ((p / 3) % 2) == 1;
  endfunction
  function automatic bit e_bck(int p, bit fast);
    int hp = fast ? 4 : 6;
    return ((p / hp) % 2) == 1;
  endfunction
  function automatic bit e_sd(int p, bit fast, logic [23:0] l, logic [23:0] r);
    int per = fast ? 8 : 12;
    int off = (p < 192) ? p : p - 192;
    logic [23:0] w = (p < 192) ? l : r;
    return w[23 - off / per];
  endfunction

  task automatic chk(input string rq, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) pos=%0d actual=%0b expected=%0b t=%0t", rq, sect, ph, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (chk_on) begin
      if (in_rst) begin
        chk("R1 conv", conv_clk, 1'b0);
        chk("R1 lr", lr_frame, 1'b0);
        chk("R1 bck", bck_a | bck_b, 1'b0);
        chk("R1 wck", wck_a | wck_b, 1'b0);
        chk("R1 sd", sd_out, 1'b0);
      end else begin
        chk("R2 lr", lr_frame, ph < 192);
        chk("R2 wck_a", wck_a, ph < 192);
        chk("R2 wck_b", wck_b, ph < 192);
        chk("R3 conv", conv_clk, e_conv(ph));
        chk("R4 bck_a", bck_a, e_bck(ph, mra));
        chk("R4 bck_b", bck_b, e_bck(ph, mrb));
        chk("R5 sd", sd_out, e_sd(ph, mra, lat_l, lat_r));
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 0; frame_int = 1; lr_ext = 0; rate_a = 0; rate_b = 0;
    smp_l = '0; smp_r = '0;
    @(negedge clk);
    chk_on = 1'b1;
    smp_l = 24'hFFFFFF; smp_r = 24'hFFFFFF;
    repeat (4) @(negedge clk);          // R1 reset state
    rst_n = 1;
    sect = "R2..R6 sweep";
    for (int c = 0; c < 4; c++) begin
      rate_a = c[0]; rate_b = c[1];
      for (int f = 0; f < 2; f++) begin
        smp_l = 24'(32'h5A3C71 ^ ((c * 2 + f) * 32'h01F3B5));
        smp_r = 24'(32'hC3965E + (c * 2 + f) * 32'h0B7D13);
        repeat (150) @(negedge clk);
        smp_l = ~smp_l; smp_r = {smp_r[11:0], smp_r[23:12]};  // R6: mid-frame change
        repeat (234) @(negedge clk);
      end
    end
    // rate pins moved at odd cycles
    for (int i = 0; i < 6; i++) begin
      rate_a = ~rate_a; repeat (53 + i * 7) @(negedge clk);
      rate_b = ~rate_b; repeat (41) @(negedge clk);
    end
    sect = "R9 internal ignores lr_ext";
    frame_int = 1;
    for (int i = 0; i < 24; i++) begin
      lr_ext = ~lr_ext; repeat (37) @(negedge clk);
    end
    sect = "R8 external, quiet input";
    lr_ext = 0;
    repeat (5) @(negedge clk);
    frame_int = 0;
    repeat (800) @(negedge clk);
    sect = "R7 latency";
    lr_ext = 1;
    repeat (3) @(negedge clk);
    chk("R7 lr after rise", lr_frame, 1'b1);
    chk("R7 conv at start", conv_clk, 1'b0);
    chk("R7 bck_a at start", bck_a, 1'b0);
    repeat (3) @(negedge clk);
    chk("R7 conv at pos 3", conv_clk, 1'b1);
    repeat (50) @(negedge clk);
    lr_ext = 0;
    repeat (3) @(negedge clk);
    chk("R7 lr after fall", lr_frame, 1'b0);
    sect = "R7 regular frames";
    repeat (77) @(negedge clk);
    for (int i = 0; i < 3; i++) begin
      lr_ext = 1; repeat (192) @(negedge clk);
      lr_ext = 0; repeat (192) @(negedge clk);
    end
    sect = "R7 irregular frames";
    rate_a = 1;
    for (int i = 0; i < 6; i++) begin
      lr_ext = 1; repeat (100) @(negedge clk);
      lr_ext = 0; repeat (150) @(negedge clk);
      rate_a = ~rate_a;
    end
    chk_on = 1'b0;
    summary();
    $finish;
  end
endmodule